// File: doc/BRIEF.md
# Threshold-Triggered Transmit Packet FIFO

This block is a single-port transmit queue placed between a byte-wide packet source and a MAC transmitter. It takes one byte per cycle, with a start and an end marker for each frame. It holds the bytes in a ring buffer and hands each frame to the MAC in order. A frame starts leaving the queue either when its stored byte count rises above a programmable threshold or when its final byte has arrived, whichever comes first. A small threshold gives cut-through operation. A threshold larger than any frame gives store-and-forward operation, because no frame can start until it is complete.

The input has no back-pressure. A byte that arrives while the ring is full is discarded, and a sticky overflow flag is raised. That flag is read through a small register port and clears when it is read. The same register port holds the 13-bit threshold. Only whole 8-byte steps of the threshold take effect. The threshold must be set higher than the longest burst the source can deliver without a gap.

Top module: `txq_thresh_fifo`

## Requirements
- R1: Register address 0 holds the threshold. It resets to 0x100, a write stores write-data bits 12:0, and a read returns those 13 bits with bits 31:13 at zero.
- R2: The effective threshold is the threshold with its low 3 bits forced to zero. A frame with no end marker stored raises out_valid only after its stored byte count exceeds the effective threshold. out_valid is high after the second rising edge that follows the write of the byte that crosses the threshold.
- R3: Storing a frame's end-marked byte starts that frame with the same latency, even when the byte count is at or below the threshold.
- R4: When the effective threshold is at least the frame length, out_valid stays low until the frame's end-marked byte has been written (store-and-forward).
- R5: Bytes leave on out_data in the order they were accepted, one per cycle in which out_valid and out_ready are both high. Each byte keeps its start and end markers on out_sof and out_eof.
- R6: Once a frame has started, it keeps draining until its end-marked byte is taken, even if the threshold changes. If the ring empties mid-frame, out_valid drops, and it rises again in the cycle after the next byte is written.
- R7: A byte offered while the ring holds DEPTH bytes is discarded. The bytes already stored come out unchanged, and the discarded byte never appears.
- R8: Register address 1 reads the overflow flag at bit position PORT_ID, with every other bit zero. The flag resets to 0 and is set by any discarded byte.
- R9: A read of address 1 returns the current flag and clears it from the next cycle on.
- R10: If a byte is discarded in the same cycle as a read of address 1, the flag is set afterwards.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sof and out_eof hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte offered on in_data this cycle |
| in_data | input | 8 | Ingress byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| out_ready | input | 1 | MAC accepts the presented byte |
| out_valid | output | 1 | A byte of a started frame is presented |
| out_data | output | 8 | Egress byte |
| out_sof | output | 1 | Presented byte is the first of its frame |
| out_eof | output | 1 | Presented byte is the last of its frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 threshold, 1 overflow flag |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |

## Verification
A byte written at one rising edge counts toward occupancy at that same edge. The start decision is registered at the next edge, so the bench expects out_valid low at the falling edge after the crossing byte is written and high one falling edge later. Register reads are combinational, so read data is sampled within the strobe cycle. The effect of a clear or a set is checked by a second read in a later cycle. Egress bytes are compared by a monitor that samples two time units after each falling edge, which is after the bench has finished driving and before the handshake edge that consumes the byte.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned REG_AW  = 2;

  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t ADDR_THR = 2'd0;
  localparam reg_addr_t ADDR_OVF = 2'd1;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_rst_sync.sv
module txq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  txq_entry_t   push_entry,
  input  logic         pop,
  output logic         push_ok,
  output logic         full,
  output logic [CW-1:0] count,
  output txq_entry_t   head
);
  txq_entry_t  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] wr_ptr_inc, rd_ptr_inc;
  logic [CW-1:0] count_q, count_d;

  assign full    = (count_q == CW'(DEPTH));
  assign push_ok = push_req && !full;

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_ptr_inc = wr_ptr_q + 1'b1;
      assign rd_ptr_inc = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_ptr_inc = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_inc = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    wr_ptr_d = push_ok ? wr_ptr_inc : wr_ptr_q;
    rd_ptr_d = pop     ? rd_ptr_inc : rd_ptr_q;
    count_d  = count_q + CW'(push_ok) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_entry;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/txq_start_ctl.sv
module txq_start_ctl #(
  parameter int unsigned CW = 12,
  parameter int unsigned TW = 13,
  localparam int unsigned CMPW = (CW > TW) ? CW : TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          push_eof,
  input  logic          head_eof,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          pop,
  output logic          active,
  output logic [CW-1:0] eof_pend
);
  logic          active_q, active_d;
  logic [CW-1:0] eof_cnt_q, eof_cnt_d;
  logic [CMPW-1:0] occ_x, thr_x;
  logic          start_go, frame_done;

  assign occ_x = CMPW'(count);
  assign thr_x = CMPW'({thr[TW-1:3], 3'b000});

  assign out_valid  = active_q && (count != '0);
  assign pop        = out_valid && out_ready;
  assign frame_done = pop && head_eof;
  assign start_go   = !active_q && (count != '0) &&
                      ((eof_cnt_q != '0) || (occ_x > thr_x));

  always_comb begin
    active_d = active_q;
    if (start_go)        active_d = 1'b1;
    else if (frame_done) active_d = 1'b0;
    eof_cnt_d = eof_cnt_q + CW'(push_ok && push_eof) - CW'(frame_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      eof_cnt_q <= '0;
    end else begin
      active_q  <= active_d;
      eof_cnt_q <= eof_cnt_d;
    end
  end

  assign active   = active_q;
  assign eof_pend = eof_cnt_q;
endmodule

// File: rtl/txq_csr.sv
module txq_csr
  import txq_pkg::*;
#(
  parameter int unsigned TW        = 13,
  parameter int unsigned DW        = 32,
  parameter logic [TW-1:0] THR_RST = 13'h100,
  parameter int unsigned PORT_ID   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  reg_addr_t     reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          ovf_evt,
  output logic [DW-1:0] reg_rdata,
  output logic [TW-1:0] thr,
  output logic          ovf_flag
);
  logic [TW-1:0] thr_q, thr_d;
  logic          ovf_q, ovf_d;
  logic          thr_we, ovf_rd;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:TW];
  assign thr_we = reg_wr && (reg_addr == ADDR_THR);
  assign ovf_rd = reg_rd && (reg_addr == ADDR_OVF);

  always_comb begin
    thr_d = thr_we ? reg_wdata[TW-1:0] : thr_q;
    ovf_d = ovf_q;
    if (ovf_evt)     ovf_d = 1'b1;
    else if (ovf_rd) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      ovf_q <= 1'b0;
    end else begin
      thr_q <= thr_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_THR)      reg_rdata = DW'(thr_q);
      else if (reg_addr == ADDR_OVF) reg_rdata = DW'(ovf_q) << PORT_ID;
    end
  end

  assign thr      = thr_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/txq_thresh_fifo.sv
module txq_thresh_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH     = 2048,
  parameter int unsigned THR_W     = 13,
  parameter int unsigned REG_DW    = 32,
  parameter logic [THR_W-1:0] THR_RST = 13'h100,
  parameter int unsigned PORT_ID   = 0,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata
);
  logic             srst_n;
  logic             push_ok, full, pop, active, ovf_flag;
  logic [CW-1:0]    occ, eof_pend;
  logic [THR_W-1:0] thr_q;
  txq_entry_t       wr_entry, head;

  txq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign wr_entry = '{sof: in_sof, eof: in_eof, data: in_data};

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .push_req(in_valid), .push_entry(wr_entry),
    .pop(pop), .push_ok(push_ok), .full(full), .count(occ), .head(head)
  );

  txq_start_ctl #(.CW(CW), .TW(THR_W)) u_ctl (
    .clk(clk), .rst_n(srst_n), .push_ok(push_ok), .push_eof(in_eof),
    .head_eof(head.eof), .count(occ), .thr(thr_q), .out_ready(out_ready),
    .out_valid(out_valid), .pop(pop), .active(active), .eof_pend(eof_pend)
  );

  txq_csr #(.TW(THR_W), .DW(REG_DW), .THR_RST(THR_RST), .PORT_ID(PORT_ID)) u_csr (
    .clk(clk), .rst_n(srst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ovf_evt(in_valid && full),
    .reg_rdata(reg_rdata), .thr(thr_q), .ovf_flag(ovf_flag)
  );

  assign out_data = head.data;
  assign out_sof  = head.sof;
  assign out_eof  = head.eof;
endmodule

// File: rtl/txq_thresh_fifo_chk.sv
module txq_thresh_fifo_chk
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned THR_W = 13,
  parameter int unsigned CW    = 12
) (
  input logic              clk,
  input logic              srst_n,
  input logic              in_valid,
  input logic              full,
  input logic [CW-1:0]     occ,
  input logic [CW-1:0]     eof_pend,
  input logic [THR_W-1:0]  thr_q,
  input logic              active,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_eof,
  input logic              out_sof,
  input logic [7:0]        out_data,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              ovf_flag
);
  logic [31:0] thr_eff32;
  assign thr_eff32 = 32'({thr_q[THR_W-1:3], 3'b000});

  AST_THR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == ADDR_THR) |-> (reg_rdata[31:THR_W] == '0)); // R1

  AST_START_JUSTIFIED: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(active) |-> $past((eof_pend != '0) || (32'(occ) > thr_eff32))); // R2

  AST_FRAME_CONTINUES: assert property (@(posedge clk) disable iff (!srst_n)
    (active && !(out_valid && out_ready && out_eof)) |=> active); // R6

  AST_DROP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && full) |=> (32'(occ) <= 32'($past(occ)))); // R7

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    32'(occ) <= DEPTH); // R7

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && full) |=> ovf_flag); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == ADDR_OVF && !(in_valid && full)) |=> !ovf_flag); // R9

  AST_OVF_RACE: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == ADDR_OVF && in_valid && full) |=> ovf_flag); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R11
endmodule

bind txq_thresh_fifo txq_thresh_fifo_chk #(
  .DEPTH(DEPTH), .THR_W(THR_W), .CW(CW)
) u_chk (
  .clk(clk), .srst_n(srst_n), .in_valid(in_valid), .full(full), .occ(occ),
  .eof_pend(eof_pend), .thr_q(thr_q), .active(active), .out_valid(out_valid),
  .out_ready(out_ready), .out_eof(out_eof), .out_sof(out_sof),
  .out_data(out_data), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
);

// File: tb/sim_txq_thresh_fifo.sv
module sim_txq_thresh_fifo;
  localparam int DEPTH   = 2048;
  localparam int PORT_ID = 3;

  logic        clk, rst_n;
  logic        in_valid, in_sof, in_eof, out_ready;
  logic [7:0]  in_data;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [9:0] exp_q[$];

  txq_thresh_fifo #(.DEPTH(DEPTH), .PORT_ID(PORT_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each egress handshake against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R7 unexpected byte", {22'd0, out_sof, out_eof, out_data}, 32'd0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({out_sof, out_eof, out_data} == e, "R5 egress byte",
              {22'd0, out_sof, out_eof, out_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drive_byte(input logic [7:0] d, input bit s, input bit e, input bit keep);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    if (keep) exp_q.push_back({s, e, d});
  endtask

  // Sends a frame with out_ready high; out_valid expected once w >= s_at
  task automatic send_frame(input int len, input logic [7:0] seed, input int s_at, input string tag);
    for (int i = 0; i < len; i++) begin
      chk(out_valid == (i >= s_at), tag, {31'd0, out_valid}, {31'd0, i >= s_at});
      drive_byte(seed + 8'(i), i == 0, i == len - 1, 1'b1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(out_valid == (len >= s_at), tag, {31'd0, out_valid}, {31'd0, len >= s_at});
    @(negedge clk);
    chk(out_valid == 1'b1, tag, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 2 * DEPTH + 50) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    out_ready = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    reg_read(2'd0, rd); chk(rd == 32'h100, "R1 threshold reset", rd, 32'h100);
    reg_read(2'd1, rd); chk(rd == 32'h0, "R8 overflow reset", rd, 32'h0);
    chk(out_valid == 1'b0, "R2 idle after reset", {31'd0, out_valid}, 32'd0);

    // R1: upper write bits dropped; R2: effective threshold 24 -> start at w=26
    reg_write(2'd0, 32'hFFFF_E01F);
    reg_read(2'd0, rd); chk(rd == 32'h1F, "R1 threshold readback", rd, 32'h1F);
    send_frame(40, 8'h10, 26, "R2 cut-through start");
    wait_drain("R5 drain frame A");

    // R3: short frame starts on its end marker
    send_frame(5, 8'h40, 6, "R3 end-marker start");
    wait_drain("R5 drain frame B");

    // R2: 0x27 rounds down to 32 -> start at w=34
    reg_write(2'd0, 32'h27);
    send_frame(40, 8'h60, 34, "R2 rounded threshold");
    wait_drain("R5 drain frame C");

    // R4: store-and-forward
    reg_write(2'd0, 32'h1FFF);
    send_frame(60, 8'h80, 61, "R4 store-and-forward");
    wait_drain("R5 drain frame D");

    // R6: underrun mid-frame, threshold change ignored after start
    reg_write(2'd0, 32'h8);
    for (int i = 0; i < 12; i++) begin
      chk(out_valid == (i >= 10), "R6 start", {31'd0, out_valid}, {31'd0, i >= 10});
      drive_byte(8'hA0 + 8'(i), i == 0, 1'b0, 1'b1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    chk(out_valid == 1'b0, "R6 underrun drops valid", {31'd0, out_valid}, 32'd0);
    reg_write(2'd0, 32'h1FFF);
    for (int i = 12; i < 20; i++) begin
      drive_byte(8'hA0 + 8'(i), 1'b0, i == 19, 1'b1);
      @(negedge clk);
      chk(out_valid == 1'b1, "R6 resumes without recheck", {31'd0, out_valid}, 32'd1);
    end
    in_valid = 1'b0;
    wait_drain("R6 drain frame E");
    chk(out_valid == 1'b0, "R6 frame ended", {31'd0, out_valid}, 32'd0);

    // R11: stall holds presented byte
    reg_write(2'd0, 32'h100);
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive_byte(8'hC0 + 8'(i), i == 0, i == 3, 1'b1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid && out_sof && out_data == 8'hC0, "R11 stalled head",
        {22'd0, out_valid, out_sof, out_data}, {22'd0, 2'b11, 8'hC0});
    repeat (3) @(negedge clk);
    chk(out_valid && out_sof && out_data == 8'hC0, "R11 still held",
        {22'd0, out_valid, out_sof, out_data}, {22'd0, 2'b11, 8'hC0});
    out_ready = 1'b1;
    wait_drain("R5 drain frame F");

    // R7..R10: fill, overflow, clear-on-read, race
    out_ready = 1'b0;
    reg_write(2'd0, 32'h1FFF);
    for (int i = 0; i < DEPTH; i++) begin
      drive_byte(8'(i * 7), i == 0, 1'b0, 1'b1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 full ring no end marker", {31'd0, out_valid}, 32'd0);
    reg_read(2'd1, rd); chk(rd == 32'h0, "R8 no overflow yet", rd, 32'h0);
    for (int i = 0; i < 3; i++) begin
      drive_byte(8'hEE, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    reg_read(2'd1, rd); chk(rd == (32'h1 << PORT_ID), "R8 overflow bit", rd, 32'h1 << PORT_ID);
    reg_read(2'd1, rd); chk(rd == 32'h0, "R9 cleared by read", rd, 32'h0);
    drive_byte(8'hEE, 1'b0, 1'b1, 1'b0);
    reg_read(2'd1, rd);
    in_valid = 1'b0;
    chk(rd == 32'h0, "R10 race read value", rd, 32'h0);
    reg_read(2'd1, rd); chk(rd == (32'h1 << PORT_ID), "R10 set wins over clear", rd, 32'h1 << PORT_ID);
    reg_write(2'd0, 32'h0);
    out_ready = 1'b1;
    wait_drain("R7 stored bytes intact");
    chk(out_valid == 1'b0, "R7 dropped bytes absent", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule